// File: doc/BRIEF.md
# DAC Warm-up Gate and Soft Volume Stepper

This block sits between the audio sample source and a stereo DAC datapath. When the DAC power enable goes high while both ADC channels are powered off, it opens a warm-up window of a fixed number of sample periods. During that window both output channels carry two's-complement zero, whatever the input holds. If either ADC channel is already powered, there is no window and samples pass through at once.

The block also applies a digital gain to each channel. After every power-up the applied volume code starts at the unity code. It then moves one code per sample strobe toward the programmed value, so the level changes in small steps and never jumps. A link input lets the left volume value drive both channels. When the DAC is powered down, the outputs go to zero and the volume stepper returns to unity, ready for the next power-up.

Top module: `dac_warmup_volume`

## Requirements
- R1: A warm-up window opens on a 0-to-1 change of `dac_pwr` only when `adc_pwr_l` and `adc_pwr_r` are both 0 in that cycle. `init_busy` is high from the next cycle.
- R2: The window lasts exactly `INIT_SAMPLES` (default 1059) sample strobes that follow the power-up. The next strobe after those carries real data to the outputs.
- R3: While the window is open, both outputs are 0 on every strobe.
- R4: If either ADC power bit is 1 at DAC power-up, `init_busy` stays low and the first strobe already passes data.
- R5: After power-up the applied volume code is 192 (0xC0, unity). On each strobe it moves by exactly one code toward the target, and it holds once it reaches the target.
- R6: If the target changes during a ramp, the stepper heads for the new target from its current code.
- R7: With `vol_link` = 1 both channels use `vol_l` as their target. With `vol_link` = 0 the right channel uses `vol_r`.
- R8: Code c splits into an octave c[7:4] and a fraction c[3:0]. The gain is 2^((c-192)/16), so 0xC0 is x1, 0xB0 is x1/2, 0xA0 is x1/4 and 0xD0 is x2. Code 0 mutes. Results saturate to +32767 and -32768, and right shifts round toward minus infinity.
- R9: While `dac_pwr` is 0, the outputs are 0, the window is closed, and the applied volume is back at unity.
- R10: `ramp_busy` is high while `dac_pwr` is 1 and a channel's applied code differs from its target. After reset, the outputs, `init_busy` and `ramp_busy` are all 0.
- R11: The outputs change only on cycles with `sample_stb` high (or on power-down). Between strobes they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dac_pwr | input | 1 | DAC power enable |
| adc_pwr_l | input | 1 | Left ADC channel power |
| adc_pwr_r | input | 1 | Right ADC channel power |
| sample_stb | input | 1 | One-cycle sample-rate strobe |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| vol_l | input | 8 | Left volume code |
| vol_r | input | 8 | Right volume code |
| vol_link | input | 1 | 1: `vol_l` drives both channels |
| out_l | output | 16 | Left output sample to the DAC |
| out_r | output | 16 | Right output sample to the DAC |
| init_busy | output | 1 | Warm-up window open |
| ramp_busy | output | 1 | Volume ramp in progress |

## Verification
The bench counts the window to the exact strobe. It checks that the last zeroed strobe is number 1059 and that data appears on number 1060. An off-by-one counter would leak one sample early or zero one extra sample. Power-up is also driven with one ADC channel on, which catches a design that ignores the ADC condition and silences the DAC needlessly.

The ramp tests count steps. In one test the target is changed mid-ramp to a target on the far side of the current code. A design that restarts from unity, or that jumps to the target, would finish with the wrong step count. The volume is also stepped down, then the DAC is powered off and on again, to expose a stepper that keeps its old code. Further tests drive the channels with link off, drive the gain into saturation in both directions, and mute with code 0.

// File: rtl/dwv_pkg.sv
// Shared constants and types for the DAC warm-up / soft volume block.
// Assumes an 8-bit volume code split into a 4-bit octave and a 4-bit fraction.
package dwv_pkg;
    localparam int VOL_W      = 8;
    localparam int FRAC_BITS  = 4;
    localparam int MANT_FRAC  = 14;                          // mantissa is Q1.14
    localparam int MANT_W     = MANT_FRAC + 1;
    localparam int UNITY_OCT  = 12;
    localparam int SHIFT_BASE = MANT_FRAC + UNITY_OCT;
    localparam logic [VOL_W-1:0] UNITY_CODE = VOL_W'(UNITY_OCT << FRAC_BITS);

    typedef logic [VOL_W-1:0] vol_code_t;

    // Fractional-octave mantissa: round(16384 * 2^(k/16)).
    function automatic logic [MANT_W-1:0] mant_of(input logic [FRAC_BITS-1:0] k);
        case (k)
            4'd0:  mant_of = 15'd16384;
            4'd1:  mant_of = 15'd17109;
            4'd2:  mant_of = 15'd17867;
            4'd3:  mant_of = 15'd18658;
            4'd4:  mant_of = 15'd19484;
            4'd5:  mant_of = 15'd20347;
            4'd6:  mant_of = 15'd21247;
            4'd7:  mant_of = 15'd22188;
            4'd8:  mant_of = 15'd23170;
            4'd9:  mant_of = 15'd24196;
            4'd10: mant_of = 15'd25268;
            4'd11: mant_of = 15'd26386;
            4'd12: mant_of = 15'd27554;
            4'd13: mant_of = 15'd28774;
            4'd14: mant_of = 15'd30048;
            default: mant_of = 15'd31379;
        endcase
    endfunction
endpackage

// File: rtl/dwv_init_window.sv
// Warm-up window counter. It opens on a DAC power rise when both ADC
// channels are off and stays open for INIT_SAMPLES sample strobes.
// Assumes INIT_SAMPLES >= 2. A strobe in the rise cycle counts toward the window.
module dwv_init_window #(
    parameter int INIT_SAMPLES = 1059
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dac_en,
    input  logic adc_l_en,
    input  logic adc_r_en,
    input  logic sample_stb,
    output logic init_start,
    output logic init_busy
);
    localparam int CW = $clog2(INIT_SAMPLES + 1);

    logic          en_q;
    logic [CW-1:0] remain;

    // Detect the qualifying power-up edge.
    assign init_start = dac_en & ~en_q & ~adc_l_en & ~adc_r_en;

    // Remember the previous power state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= dac_en;
    end

    // Load, count down per strobe, and clear on power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || !dac_en) begin
            remain    <= '0;
            init_busy <= 1'b0;
        end else if (init_start) begin
            remain    <= sample_stb ? CW'(INIT_SAMPLES - 1) : CW'(INIT_SAMPLES);
            init_busy <= 1'b1;
        end else if (init_busy && sample_stb) begin
            remain <= remain - 1'b1;
            if (remain == CW'(1)) init_busy <= 1'b0;
        end
    end

    a_r1_needs_adc_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_busy) |-> !$past(adc_l_en) && !$past(adc_r_en));
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> (remain != '0) && (remain <= CW'(INIT_SAMPLES)));
endmodule

// File: rtl/dwv_vol_ramp.sv
// Soft volume stepper for one channel. It moves the applied code one step per
// strobe toward the target and rests at unity while the DAC is off.
// Assumes the target may change at any cycle.
module dwv_vol_ramp
    import dwv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dac_en,
    input  logic      sample_stb,
    input  vol_code_t target,
    output vol_code_t applied,
    output logic      ramping
);
    // Step the applied code by one toward the target on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !dac_en)                     applied <= UNITY_CODE;
        else if (sample_stb && applied < target)   applied <= applied + 1'b1;
        else if (sample_stb && applied > target)   applied <= applied - 1'b1;
    end

    // Report an unfinished ramp.
    assign ramping = dac_en && (applied != target);

    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dac_en) && applied != $past(applied)) |->
            (applied == $past(applied) + 8'd1 || applied == $past(applied) - 8'd1));
    a_r9_rest_unity: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_en |=> applied == UNITY_CODE);
endmodule

// File: rtl/dwv_gain.sv
// Combinational gain stage: it scales a signed sample by 2^((code-192)/16)
// using a mantissa lookup and an octave shift, then saturates. Code 0 mutes.
module dwv_gain
    import dwv_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] sample_in,
    input  vol_code_t                code,
    output logic signed [DATA_W-1:0] sample_out
);
    localparam int PW = DATA_W + MANT_W + 1;
    localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -PW'(2 ** (DATA_W - 1));

    logic        [MANT_W-1:0] mant;
    logic        [4:0]        shamt;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     scaled;

    // Multiply by the mantissa, shift by the octave, then clamp.
    always_comb begin
        mant   = mant_of(code[FRAC_BITS-1:0]);
        shamt  = 5'(SHIFT_BASE) - 5'(code[VOL_W-1:FRAC_BITS]);
        prod   = PW'(sample_in) * $signed({1'b0, mant});
        scaled = prod >>> shamt;
        if (code == '0)         sample_out = '0;
        else if (scaled > MAXV) sample_out = MAXV[DATA_W-1:0];
        else if (scaled < MINV) sample_out = MINV[DATA_W-1:0];
        else                    sample_out = scaled[DATA_W-1:0];
    end
endmodule

// File: rtl/dac_warmup_volume.sv
// Top level: the warm-up window gate plus per-channel soft volume in front of
// a stereo DAC. Outputs are registered and update on sample strobes.
// Assumes sample_stb is a single-cycle pulse at the sample rate.
module dac_warmup_volume
    import dwv_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int INIT_SAMPLES = 1059
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dac_pwr,
    input  logic              adc_pwr_l,
    input  logic              adc_pwr_r,
    input  logic              sample_stb,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    input  logic [VOL_W-1:0]  vol_l,
    input  logic [VOL_W-1:0]  vol_r,
    input  logic              vol_link,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              init_busy,
    output logic              ramp_busy
);
    localparam int NCH = 2;

    logic                     init_start;
    logic                     force_zero;
    vol_code_t                tgt     [NCH];
    vol_code_t                applied [NCH];
    logic      [NCH-1:0]      ramping;
    logic      [DATA_W-1:0]   din     [NCH];
    logic signed [DATA_W-1:0] gained  [NCH];
    logic      [DATA_W-1:0]   dout    [NCH];

    dwv_init_window #(.INIT_SAMPLES(INIT_SAMPLES)) u_window (
        .clk(clk), .rst_n(rst_n), .dac_en(dac_pwr),
        .adc_l_en(adc_pwr_l), .adc_r_en(adc_pwr_r), .sample_stb(sample_stb),
        .init_start(init_start), .init_busy(init_busy)
    );

    // Pick targets: the right channel follows left when linked.
    assign tgt[0] = vol_l;
    assign tgt[1] = vol_link ? vol_l : vol_r;
    assign din[0] = in_l;
    assign din[1] = in_r;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dwv_vol_ramp u_ramp (
            .clk(clk), .rst_n(rst_n), .dac_en(dac_pwr), .sample_stb(sample_stb),
            .target(tgt[ch]), .applied(applied[ch]), .ramping(ramping[ch])
        );
        dwv_gain #(.DATA_W(DATA_W)) u_gain (
            .sample_in($signed(din[ch])), .code(applied[ch]), .sample_out(gained[ch])
        );

        // Register the channel output once per strobe, zeroed when gated.
        always_ff @(posedge clk) begin
            if (!rst_n || !dac_pwr)  dout[ch] <= '0;
            else if (sample_stb)     dout[ch] <= force_zero ? '0 : gained[ch];
        end
    end

    assign force_zero = init_busy | init_start;
    assign ramp_busy  = |ramping;
    assign out_l      = dout[0];
    assign out_r      = dout[1];

    a_r3_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |-> (out_l == '0) && (out_r == '0));
    a_r9_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_pwr |=> (out_l == '0) && (out_r == '0));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_stb && dac_pwr) |=> $stable(out_l) && $stable(out_r));
endmodule

// File: tb/dac_warmup_volume_test.sv
// Directed bench: one task per scenario, each checking its own results.
module dac_warmup_volume_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dac_pwr = 1'b0, adc_pwr_l = 1'b0, adc_pwr_r = 1'b0, sample_stb = 1'b0;
    logic [15:0] in_l = '0, in_r = '0;
    logic [7:0]  vol_l = 8'hC0, vol_r = 8'hC0;
    logic        vol_link = 1'b1;
    logic [15:0] out_l, out_r;
    logic        init_busy, ramp_busy;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    dac_warmup_volume uut (
        .clk(clk), .rst_n(rst_n), .dac_pwr(dac_pwr), .adc_pwr_l(adc_pwr_l),
        .adc_pwr_r(adc_pwr_r), .sample_stb(sample_stb), .in_l(in_l), .in_r(in_r),
        .vol_l(vol_l), .vol_r(vol_r), .vol_link(vol_link), .out_l(out_l),
        .out_r(out_r), .init_busy(init_busy), .ramp_busy(ramp_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sl(); return int'($signed(out_l)); endfunction
    function automatic int sr(); return int'($signed(out_r)); endfunction

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sample_stb = 1'b1;
            @(negedge clk) sample_stb = 1'b0;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset out_l", sl(), 0);
        chk("R10 reset out_r", sr(), 0);
        chk("R10 reset init_busy", init_busy, 0);
        chk("R10 reset ramp_busy", ramp_busy, 0);
    endtask

    task automatic t_window;
        in_l = 16'sd1000; in_r = -16'sd1000;
        @(negedge clk) dac_pwr = 1'b1;
        @(negedge clk);
        chk("R1 window opens", init_busy, 1);
        strobe(1058);
        chk("R2 still open after 1058", init_busy, 1);
        chk("R3 zero left in window", sl(), 0);
        chk("R3 zero right in window", sr(), 0);
        strobe(1);
        chk("R2 closed after 1059", init_busy, 0);
        chk("R2 last window sample zero", sl(), 0);
        strobe(1);
        chk("R2 data after window left", sl(), 1000);
        chk("R2 data after window right", sr(), -1000);
        in_l = 16'sd77;
        repeat (3) @(negedge clk);
        chk("R11 hold between strobes", sl(), 1000);
    endtask

    task automatic t_power_cycle;
        vol_l = 8'hD0;
        strobe(5);
        chk("R10 ramp_busy while ramping", ramp_busy, 1);
        chk("R9 nonzero before power-down", (sl() != 0) ? 1 : 0, 1);
        dac_pwr = 1'b0; vol_l = 8'hC0; adc_pwr_l = 1'b1;
        @(negedge clk);
        chk("R9 off left zero", sl(), 0);
        chk("R9 off right zero", sr(), 0);
        chk("R10 off ramp_busy", ramp_busy, 0);
        dac_pwr = 1'b1; in_l = 16'sd1000;
        @(negedge clk);
        chk("R4 no window with ADC on", init_busy, 0);
        strobe(1);
        chk("R4 R9 immediate data at unity", sl(), 1000);
    endtask

    task automatic t_ramp;
        vol_l = 8'hB0;
        strobe(1);
        chk("R5 first strobe still unity", sl(), 1000);
        chk("R10 ramp_busy high", ramp_busy, 1);
        strobe(15);
        chk("R5 ramp done after 16", ramp_busy, 0);
        strobe(3);
        chk("R5 R8 half gain left", sl(), 500);
        chk("R5 R8 half gain right", sr(), -500);
    endtask

    task automatic t_retarget;
        in_l = 16'sd4000; in_r = -16'sd4000;
        vol_l = 8'hC0;
        strobe(4);
        vol_l = 8'hA0;
        strobe(19);
        chk("R6 still ramping after 19", ramp_busy, 1);
        strobe(1);
        chk("R6 retarget reached after 20", ramp_busy, 0);
        strobe(1);
        chk("R6 R8 quarter gain left", sl(), 1000);
        chk("R6 R8 quarter gain right", sr(), -1000);
    endtask

    task automatic t_link;
        vol_link = 1'b0; vol_r = 8'hB0;
        strobe(16);
        chk("R7 unlinked ramp done", ramp_busy, 0);
        strobe(1);
        chk("R7 left own volume", sl(), 1000);
        chk("R7 right own volume", sr(), -2000);
        vol_link = 1'b1;
        strobe(16);
        strobe(1);
        chk("R7 linked right follows left", sr(), -1000);
    endtask

    task automatic t_gain;
        in_l = 16'sd20000; in_r = -16'sd20000;
        vol_l = 8'hD0;
        strobe(49);
        chk("R8 saturate high", sl(), 32767);
        chk("R8 saturate low", sr(), -32768);
        in_l = 16'sd1234; in_r = 16'sd1234;
        vol_l = 8'h00;
        strobe(209);
        chk("R8 mute ramp done", ramp_busy, 0);
        chk("R8 code 0 mutes", sl(), 0);
    endtask

    initial begin
        t_reset();
        t_window();
        t_power_cycle();
        t_ramp();
        t_retarget();
        t_link();
        t_gain();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule